// File: doc/BRIEF.md
# Transaction Class Ordering Queue

The block sits behind one ingress port of an interconnect. Each arriving transaction carries a two-bit class code: posted write, message, non-posted request or completion. Posted writes and messages obey the same ordering rules, so they share one queue. Non-posted requests and completions each have a queue of their own. Every accepted entry is stamped from a wrapping sequence counter. The arbiter compares head stamps to find out whether any posted entry is older than a waiting request or completion.

The egress side has one ready line per queue. The consumer can therefore stall non-posted traffic and still take posted writes and completions. In each cycle the block presents at most one transaction. It picks the oldest head that the ordering rules allow and whose ready is high. A queue head that is younger than a queued posted entry is fenced until that posted entry has left. Back-pressure rules at the ingress: a transaction transfers in a cycle where `in_valid` and `in_ready` are both high. `in_ready` depends on `in_code` and on queue occupancy. Back-pressure rules at the egress: `eg_valid[i]` is raised only while `eg_ready[i]` is high, and a raised valid is a completed transfer in that cycle. Ordering across different ingress ports is handled elsewhere.

Top module: `txn_order_queue`

## Requirements
- R1: After reset all queues are empty. `eg_valid` is 0 and `in_ready` is 1 for every class code.
- R2: Class codes are 2'b00 posted write, 2'b01 message, 2'b10 non-posted request and 2'b11 completion. Codes 00 and 01 share queue 0, code 10 uses queue 1 and code 11 uses queue 2. Each queue holds DEPTH (4) entries, and `in_ready` is low when the queue selected by `in_code` is full. An issued transaction shows on `eg_code`/`eg_hdr` the code and header it was accepted with.
- R3: Posted writes and messages leave in the order they were accepted. They may leave ahead of an older non-posted request whose ready is low.
- R4: A non-posted request is never issued while an older posted write or message is still queued.
- R5: A completion is never issued while an older posted write or message is still queued.
- R6: A completion may leave ahead of an older non-posted request whose ready is low. Within queue 1 and within queue 2, entries leave in acceptance order.
- R7: Bits 0, 1 and 2 of `eg_valid`/`eg_ready` belong to queues 0, 1 and 2. At most one `eg_valid` bit is high, and only on a queue whose ready is high and whose head is allowed by R4/R5. If such a head exists, one is issued.
- R8: Among the heads that may be issued, the one accepted earliest wins. Queue 0 wins a tie.
- R9: A non-posted stall does not block acceptance into queues 0 and 2 while they have space. The one exception: ingress holds when the stamp counter is 2^(STAMP_W-1)-1 (127 by default) ahead of the oldest queued entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress transaction valid |
| in_ready | output | 1 | Ingress can accept the offered class |
| in_code | input | 2 | Class code of the offered transaction |
| in_hdr | input | HDR_W | Header of the offered transaction |
| eg_ready | input | 3 | Per-queue consumer ready (posted, non-posted, completion) |
| eg_valid | output | 3 | Per-queue issue strobe, at most one high |
| eg_code | output | 2 | Class code of the issued transaction |
| eg_hdr | output | HDR_W | Header of the issued transaction |

## Verification
The bench targets a completion or request that arrives after a posted write. A design without the stamp fence would issue it early, ahead of that write. It stalls non-posted traffic for long stretches. A design that serialises all classes would then starve posted writes and completions, and one with a too-narrow stamp window would misjudge ages after the counter wraps. It fills each queue to the brim to catch an overflow or a missing hold. When several heads are ready at once, it checks the choice of winner, which exposes a design that favours a fixed class over the oldest entry.

// File: rtl/txn_order_pkg.sv
package txn_order_pkg;

  typedef enum logic [1:0] {
    TC_PWR = 2'b00,
    TC_MSG = 2'b01,
    TC_NPR = 2'b10,
    TC_CPL = 2'b11
  } txn_code_e;

  localparam int NUM_Q  = 3;
  localparam int Q_POST = 0;
  localparam int Q_NPR  = 1;
  localparam int Q_CPL  = 2;

  // Map a class code onto its queue index.
  function automatic logic [1:0] queue_of(input logic [1:0] code);
    if (!code[1])     return 2'd0;
    else if (!code[0]) return 2'd1;
    else              return 2'd2;
  endfunction

endpackage

// File: rtl/txn_class_fifo.sv
module txn_class_fifo #(
  parameter int DW    = 42,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [DW-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/txn_order_arb.sv
module txn_order_arb #(
  parameter int SW = 8
) (
  input  logic [2:0]         nonempty,
  input  logic [2:0][SW-1:0] head_stamp,
  input  logic [2:0]         ready,
  output logic [2:0]         grant,
  output logic               any_live,
  output logic [SW-1:0]      oldest_stamp
);
  // a is older than b when b - a lies in the lower half of the stamp circle
  function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = b - a;
    return (d != '0) && !d[SW-1];
  endfunction

  logic [2:0] elig, cand;

  always_comb begin
    // posted head is always free to go; the others wait behind older posted
    elig[0] = nonempty[0];
    elig[1] = nonempty[1] && (!nonempty[0] || older(head_stamp[1], head_stamp[0]));
    elig[2] = nonempty[2] && (!nonempty[0] || older(head_stamp[2], head_stamp[0]));
    cand    = elig & ready;

    grant[0] = cand[0]
             && (!cand[1] || !older(head_stamp[1], head_stamp[0]))
             && (!cand[2] || !older(head_stamp[2], head_stamp[0]));
    grant[1] = cand[1] && !grant[0]
             && (!cand[2] || !older(head_stamp[2], head_stamp[1]));
    grant[2] = cand[2] && !grant[0] && !grant[1];
  end

  always_comb begin
    any_live     = |nonempty;
    oldest_stamp = '0;
    for (int i = 0; i < 3; i++) begin
      if (nonempty[i]) begin
        if (!any_live_before(i) || older(head_stamp[i], oldest_stamp))
          oldest_stamp = head_stamp[i];
      end
    end
  end

  function automatic logic any_live_before(input int idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < 3; k++) if (k < idx && nonempty[k]) r = 1'b1;
    return r;
  endfunction

endmodule

// File: rtl/txn_order_queue.sv
module txn_order_queue
  import txn_order_pkg::*;
#(
  parameter int HDR_W   = 32,
  parameter int DEPTH   = 4,
  parameter int STAMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_code,
  input  logic [HDR_W-1:0] in_hdr,
  input  logic [2:0]       eg_ready,
  output logic [2:0]       eg_valid,
  output logic [1:0]       eg_code,
  output logic [HDR_W-1:0] eg_hdr
);
  localparam int TOTAL    = NUM_Q * DEPTH;
  localparam int MIN_SW   = $clog2(TOTAL) + 1;
  localparam int SW       = (STAMP_W < MIN_SW) ? MIN_SW : STAMP_W;
  localparam int EW       = SW + 2 + HDR_W;
  localparam logic [SW-1:0] HOLD_AGE = SW'((2 ** (SW - 1)) - 1);

  logic [SW-1:0]       stamp_cnt;
  logic [2:0]          q_full, q_empty, q_push, grant;
  logic [2:0][EW-1:0]  q_head;
  logic [2:0][SW-1:0]  head_stamp;
  logic [EW-1:0]       new_entry;
  logic [1:0]          in_q;
  logic                any_live, win_ok, accept;
  logic [SW-1:0]       oldest_stamp, age;

  assign in_q      = queue_of(in_code);
  assign age       = stamp_cnt - oldest_stamp;
  assign win_ok    = !any_live || (age < HOLD_AGE);
  assign in_ready  = !q_full[in_q] && win_ok;
  assign accept    = in_valid && in_ready;
  assign new_entry = {stamp_cnt, in_code, in_hdr};

  genvar g;
  generate
    for (g = 0; g < NUM_Q; g++) begin : g_q
      assign q_push[g]     = accept && (in_q == 2'(g));
      assign head_stamp[g] = q_head[g][EW-1 -: SW];

      txn_class_fifo #(.DW(EW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push[g]),
        .push_data (new_entry),
        .pop       (grant[g]),
        .full      (q_full[g]),
        .empty     (q_empty[g]),
        .head      (q_head[g])
      );
    end
  endgenerate

  txn_order_arb #(.SW(SW)) u_arb (
    .nonempty     (~q_empty),
    .head_stamp   (head_stamp),
    .ready        (eg_ready),
    .grant        (grant),
    .any_live     (any_live),
    .oldest_stamp (oldest_stamp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) stamp_cnt <= '0;
    else if (accept) stamp_cnt <= stamp_cnt + SW'(1);
  end

  always_comb begin
    eg_valid = grant;
    eg_code  = '0;
    eg_hdr   = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (grant[i]) begin
        eg_code = q_head[i][HDR_W +: 2];
        eg_hdr  = q_head[i][HDR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/txn_order_queue_chk.sv
module txn_order_queue_chk #(
  parameter int HDR_W = 32,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_code,
  input logic [2:0]       eg_ready,
  input logic [2:0]       eg_valid,
  input logic [1:0]       eg_code
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ [3];
  logic [1:0]    sel;

  assign sel = !in_code[1] ? 2'd0 : (!in_code[0] ? 2'd1 : 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) occ[i] <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        occ[i] <= occ[i]
                + CW'(in_valid && in_ready && (sel == 2'(i)))
                - CW'(eg_valid[i]);
      end
    end
  end

  a_r7_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eg_valid));

  a_r7_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_valid & ~eg_ready) == 3'b000);

  a_r2_code_matches_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_valid[0] |-> !eg_code[1]) and (eg_valid[1] |-> eg_code == 2'b10)
    and (eg_valid[2] |-> eg_code == 2'b11));

  a_r2_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && occ[sel] == CW'(DEPTH)) |-> !in_ready);

  a_r1_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[0] == '0 && occ[1] == '0 && occ[2] == '0) |-> eg_valid == 3'b000);

endmodule

bind txn_order_queue txn_order_queue_chk #(.HDR_W(HDR_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_code  (in_code),
  .eg_ready (eg_ready),
  .eg_valid (eg_valid),
  .eg_code  (eg_code)
);

// File: tb/txn_order_queue_test.sv
`timescale 1ns/1ps
module txn_order_queue_test;
  localparam int HW = 32;
  localparam int DEP = 4;
  localparam int HOLD = 127;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_code = 2'b00;
  logic [HW-1:0] in_hdr = '0;
  logic [2:0]    eg_ready = 3'b000;
  logic [2:0]    eg_valid;
  logic [1:0]    eg_code;
  logic [HW-1:0] eg_hdr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  int            mseq  [3][DEP];
  logic [1:0]    mcode [3][DEP];
  logic [HW-1:0] mhdr  [3][DEP];
  int            mcnt  [3];
  int            next_seq = 0;

  always #2 clk = ~clk;

  txn_order_queue #(.HDR_W(HW), .DEPTH(DEP), .STAMP_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_hdr(in_hdr), .eg_ready(eg_ready),
    .eg_valid(eg_valid), .eg_code(eg_code), .eg_hdr(eg_hdr)
  );

  function automatic int qof(input logic [1:0] c);
    return !c[1] ? 0 : (!c[0] ? 1 : 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] code,
                      input logic [HW-1:0] hdr, input logic [2:0] rdy);
    bit   elig [3];
    bit   cand [3];
    int   gq, ncand, oldest;
    bit   live, exp_rdy;
    logic [2:0] exp_v;
    string tag;
    @(negedge clk);
    in_valid = v; in_code = code; in_hdr = hdr; eg_ready = rdy;
    #1;
    live = 0; oldest = 0;
    for (int i = 0; i < 3; i++)
      if (mcnt[i] > 0 && (!live || mseq[i][0] < oldest)) begin
        oldest = mseq[i][0]; live = 1;
      end
    exp_rdy = (mcnt[qof(code)] < DEP) && (!live || (next_seq - oldest) < HOLD);
    tag = (!rdy[1] && qof(code) != 1) || !exp_rdy && mcnt[qof(code)] < DEP ? "R9" : "R2";
    chk(in_ready === exp_rdy, tag, "in_ready", 64'(in_ready), 64'(exp_rdy));

    elig[0] = mcnt[0] > 0;
    elig[1] = mcnt[1] > 0 && (mcnt[0] == 0 || mseq[1][0] < mseq[0][0]);
    elig[2] = mcnt[2] > 0 && (mcnt[0] == 0 || mseq[2][0] < mseq[0][0]);
    gq = -1; ncand = 0;
    for (int i = 0; i < 3; i++) begin
      cand[i] = elig[i] && rdy[i];
      if (cand[i]) begin
        ncand++;
        if (gq < 0 || mseq[i][0] < mseq[gq][0]) gq = i;
      end
    end
    exp_v = (gq < 0) ? 3'b000 : 3'(1 << gq);
    if (gq == 0) tag = "R3";
    else if (gq == 1) tag = "R4";
    else if (gq == 2) tag = (mcnt[1] > 0 && mseq[1][0] < mseq[2][0]) ? "R6" : "R5";
    else tag = "R7";
    if (ncand > 1) tag = "R8";
    chk(eg_valid === exp_v, tag, "eg_valid", 64'(eg_valid), 64'(exp_v));
    if (gq >= 0) begin
      chk(eg_code === mcode[gq][0], "R2", "eg_code", 64'(eg_code), 64'(mcode[gq][0]));
      chk(eg_hdr === mhdr[gq][0], "R6", "eg_hdr order", 64'(eg_hdr), 64'(mhdr[gq][0]));
    end

    @(posedge clk);
    if (gq >= 0) begin
      for (int k = 0; k < DEP - 1; k++) begin
        mseq[gq][k] = mseq[gq][k+1]; mcode[gq][k] = mcode[gq][k+1];
        mhdr[gq][k] = mhdr[gq][k+1];
      end
      mcnt[gq]--;
    end
    if (v && exp_rdy) begin
      mseq[qof(code)][mcnt[qof(code)]]  = next_seq;
      mcode[qof(code)][mcnt[qof(code)]] = code;
      mhdr[qof(code)][mcnt[qof(code)]]  = hdr;
      mcnt[qof(code)]++;
      next_seq++;
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 3; i++) mcnt[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(eg_valid === 3'b000, "R1", "eg_valid after reset", 64'(eg_valid), 64'd0);
    for (int c = 0; c < 4; c++) begin
      in_code = 2'(c); #0.1;
      chk(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    end

    // R2: fill queue 0 with writes and messages, nothing ready
    for (int i = 0; i < 6; i++) step(1'b1, 2'(i & 1), 32'h100 + 32'(i), 3'b000);
    // R9: non-posted stalled, completions still accepted
    for (int i = 0; i < 3; i++) step(1'b1, 2'b11, 32'h200 + 32'(i), 3'b000);
    // drain posted first, completions follow (R5)
    for (int i = 0; i < 10; i++) step(1'b0, 2'b00, 32'h0, 3'b111);

    // R6: NP older than posted and completion, NP stalled
    step(1'b1, 2'b10, 32'h300, 3'b000);
    step(1'b1, 2'b00, 32'h301, 3'b000);
    step(1'b1, 2'b11, 32'h302, 3'b000);
    step(1'b1, 2'b01, 32'h303, 3'b000);
    for (int i = 0; i < 6; i++) step(1'b0, 2'b00, 32'h0, 3'b101);
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 32'h0, 3'b111);

    // R8: all ready, mixed arrival
    step(1'b1, 2'b11, 32'h400, 3'b000);
    step(1'b1, 2'b10, 32'h401, 3'b000);
    step(1'b1, 2'b00, 32'h402, 3'b000);
    for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 32'h0, 3'b111);

    // R9: stamp window hold under a long non-posted stall
    step(1'b1, 2'b10, 32'h500, 3'b000);
    for (int i = 0; i < 150; i++) step(1'b1, 2'(i & 1), 32'h600 + 32'(i), 3'b101);
    for (int i = 0; i < 8; i++) step(1'b0, 2'b00, 32'h0, 3'b111);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] r;
      r = 3'($urandom);
      if ((n / 300) % 2 == 1) r[1] = 1'b0;
      step(($urandom % 4) != 0, 2'($urandom), $urandom, r);
    end
    for (int i = 0; i < 20; i++) step(1'b0, 2'b00, 32'h0, 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule